// File: doc/BRIEF.md
# Isochronous split-transaction sequencer

This block sits in a host controller's periodic schedule walker and makes the per-micro-frame decision for one isochronous IN split descriptor: issue a start-split, issue a complete-split, or issue nothing. For each visit it is handed the micro-frame index, the descriptor's start and completion masks, its split state, its active bit, its transfer count and the terminate bit of its back-link. It then drives a single transaction command, waits for the device response, and emits the updated descriptor fields for write-back.

Some transfers start late in one frame and complete early in the next. For these, the current descriptor carries completion bits in micro-frames before its own start bit and a live back-link. In those micro-frames the block requests the back-linked descriptor, runs the complete-split against that descriptor's state, and then returns to the current one. Once the back-linked descriptor finishes, the block marks it retired for the rest of the frame. It skips its remaining wrap complete-splits and puts the current descriptor back into the start state, ready for its start-split.

Descriptor memory, the bus engine and the data path are outside the block. Each is reached through a simple request/response port.

Top module: `isosplit_seq`

## Requirements
- R1: After reset, `cmd_valid_o`, `bk_req_o`, `wb_valid_o` and `done_o` are all low.
- R2: On an active descriptor in the start state (`cur_cplt_i`=0) whose start-mask bit for `uframe_i` is set, exactly one start-split is issued on the current descriptor (`cmd_start_o`=1, `cmd_back_o`=0). A non-error response writes back the current descriptor with active=1, split state=complete, count unchanged and err=0.
- R3: While the split state is start, completion-mask bits are ignored. If the start-mask bit for `uframe_i` is clear, the visit issues no command and no write-back.
- R4: On an active descriptor in the complete state whose completion-mask bit for `uframe_i` is set, a complete-split is issued on the current descriptor. This holds when the back-link terminate bit is 1, or when `uframe_i` is not below the lowest start-mask bit.
- R5: Response code 0 (final data) to a complete-split writes back count+1, active=0 and split state=start.
- R6: Response code 1 (more data) to a complete-split writes back count+1 and leaves active and split state unchanged.
- R7: Response code 2 (not yet) causes no write-back. Response code 3 (error) to any command writes back err=1, active=0, split state=start and count unchanged.
- R8: A wrap visit is an active descriptor in the complete state, with its completion bit set at `uframe_i`, `uframe_i` below its lowest start-mask bit, and `back_t_i`=0. On a wrap visit the block raises `bk_req_o`. If the back-linked descriptor is active and in the complete state, it issues a complete-split with `cmd_back_o`=1 and updates that descriptor's count per R5–R7, with write-back flagged `wb_back_o`=1.
- R9: When the back-linked descriptor retires (code 0 or 3), its write-back is followed in the next cycle by a current-descriptor write-back with split state=start. Later wrap visits in the same frame (micro-frame index not 0) issue no fetch and no command. They write back only the current descriptor with split state=start. A visit at micro-frame 0 clears the retired memory.
- R10: A fetched back-linked descriptor that is inactive or in the start state counts as retired. No command is issued, and the current descriptor is written back with split state=start.
- R11: On an active descriptor in the complete state with `back_t_i`=0 whose start-mask bit for `uframe_i` is set (and no wrap condition), a start-split is issued on the current descriptor.
- R12: A visit with `cur_active_i`=0 issues no command, no fetch and no write-back.
- R13: At most one of `cmd_valid_o`, `bk_req_o`, `wb_valid_o`, `done_o` is high in any cycle. `cmd_valid_o` stays high until `rsp_valid_i`. Each visit ends with a one-cycle `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| visit_valid_i | input | 1 | Start a visit (accepted when idle) |
| uframe_i | input | 3 | Micro-frame index 0–7 |
| smask_i | input | 8 | Start mask, bit per micro-frame |
| cmask_i | input | 8 | Completion mask, bit per micro-frame |
| back_t_i | input | 1 | Back-link terminate bit (0 = back-link live) |
| cur_active_i | input | 1 | Current descriptor active bit |
| cur_cplt_i | input | 1 | Current split state (1 = do complete-split) |
| cur_cnt_i | input | 4 | Current transfer count |
| bk_req_o | output | 1 | Request for back-linked descriptor |
| bk_vld_i | input | 1 | Back-linked descriptor fields valid |
| bk_active_i | input | 1 | Back-linked active bit |
| bk_cplt_i | input | 1 | Back-linked split state |
| bk_cnt_i | input | 4 | Back-linked transfer count |
| cmd_valid_o | output | 1 | Transaction command outstanding |
| cmd_start_o | output | 1 | 1 = start-split, 0 = complete-split |
| cmd_back_o | output | 1 | Command targets the back-linked descriptor |
| rsp_valid_i | input | 1 | Response handshake |
| rsp_code_i | input | 2 | 0 final data, 1 more data, 2 not yet, 3 error |
| wb_valid_o | output | 1 | Write-back strobe |
| wb_back_o | output | 1 | Write-back targets back-linked descriptor |
| wb_active_o | output | 1 | Written active bit |
| wb_cplt_o | output | 1 | Written split state |
| wb_err_o | output | 1 | Written error flag |
| wb_cnt_o | output | 4 | Written transfer count |
| done_o | output | 1 | Visit finished (one cycle) |

## Verification
All outputs come from registered state. A fetch request or command appears one cycle after the accepting edge, a write-back one cycle after the response or fetch edge, a second (current) write-back one cycle after a back write-back, and `done_o` one cycle after the last of these. The bench does not count to fixed offsets. It drives handshakes and samples every output at the falling edge, records the command, fetch and write-backs it sees until `done_o`, and compares that record with a model that also carries its own retired-in-frame memory across visits.

// File: rtl/isosplit_pkg.sv
package isosplit_pkg;
  localparam int CNT_W = 4;

  typedef struct packed {
    logic             active;
    logic             cplt;
    logic             err;
    logic [CNT_W-1:0] cnt;
  } desc_t;

  typedef enum logic [1:0] {
    RSP_DATA0 = 2'd0,
    RSP_MDATA = 2'd1,
    RSP_NYET  = 2'd2,
    RSP_ERR   = 2'd3
  } rsp_e;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_START,
    ACT_CPLT,
    ACT_WRAP,
    ACT_SKIP
  } act_e;
endpackage

// File: rtl/isosplit_decide.sv
module isosplit_decide
  import isosplit_pkg::*;
#(
  parameter int UF_N = 8,
  localparam int UF_W = $clog2(UF_N)
) (
  input  logic [UF_W-1:0] uf_i,
  input  logic [UF_N-1:0] smask_i,
  input  logic [UF_N-1:0] cmask_i,
  input  logic            back_t_i,
  input  logic            active_i,
  input  logic            cplt_i,
  input  logic            retired_i,
  output act_e            act_o
);
  logic [UF_W:0] lowest;
  logic          win;

  always_comb begin
    lowest = (UF_W+1)'(UF_N);
    for (int i = UF_N-1; i >= 0; i--)
      if (smask_i[i]) lowest = (UF_W+1)'(i);
  end

  // completion slot ahead of own start slot with live back-link = wrap slot
  assign win = cplt_i && cmask_i[uf_i] && ({1'b0, uf_i} < lowest) && !back_t_i;

  always_comb begin
    act_o = ACT_NONE;
    if (active_i) begin
      if (win)                                act_o = retired_i ? ACT_SKIP : ACT_WRAP;
      else if (smask_i[uf_i] && (!cplt_i || !back_t_i)) act_o = ACT_START;
      else if (cplt_i && cmask_i[uf_i])       act_o = ACT_CPLT;
    end
  end
endmodule

// File: rtl/isosplit_update.sv
module isosplit_update
  import isosplit_pkg::*;
(
  input  desc_t d_i,
  input  logic  start_i,
  input  rsp_e  code_i,
  output desc_t d_o,
  output logic  wb_o,
  output logic  retire_o
);
  always_comb begin
    d_o      = d_i;
    wb_o     = 1'b1;
    retire_o = 1'b0;
    if (code_i == RSP_ERR) begin
      d_o.err    = 1'b1;
      d_o.active = 1'b0;
      d_o.cplt   = 1'b0;
      retire_o   = !start_i;
    end else if (start_i) begin
      d_o.cplt = 1'b1;
    end else begin
      unique case (code_i)
        RSP_DATA0: begin
          d_o.cnt    = d_i.cnt + 1'b1;
          d_o.active = 1'b0;
          d_o.cplt   = 1'b0;
          retire_o   = 1'b1;
        end
        RSP_MDATA: d_o.cnt = d_i.cnt + 1'b1;
        default:   wb_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/isosplit_seq.sv
module isosplit_seq
  import isosplit_pkg::*;
#(
  parameter int UF_N = 8,
  localparam int UF_W = $clog2(UF_N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             visit_valid_i,
  input  logic [UF_W-1:0]  uframe_i,
  input  logic [UF_N-1:0]  smask_i,
  input  logic [UF_N-1:0]  cmask_i,
  input  logic             back_t_i,
  input  logic             cur_active_i,
  input  logic             cur_cplt_i,
  input  logic [CNT_W-1:0] cur_cnt_i,
  output logic             bk_req_o,
  input  logic             bk_vld_i,
  input  logic             bk_active_i,
  input  logic             bk_cplt_i,
  input  logic [CNT_W-1:0] bk_cnt_i,
  output logic             cmd_valid_o,
  output logic             cmd_start_o,
  output logic             cmd_back_o,
  input  logic             rsp_valid_i,
  input  logic [1:0]       rsp_code_i,
  output logic             wb_valid_o,
  output logic             wb_back_o,
  output logic             wb_active_o,
  output logic             wb_cplt_o,
  output logic             wb_err_o,
  output logic [CNT_W-1:0] wb_cnt_o,
  output logic             done_o
);
  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_ISSUE, S_WB_BK, S_WB_CUR, S_FIN} st_e;

  st_e   st_q;
  desc_t cur_q, bk_q, upd_d;
  logic  start_q, tgt_q, retired_q, rt_q;
  logic  upd_wb, upd_retire;
  act_e  act;

  isosplit_decide #(.UF_N(UF_N)) u_decide (
    .uf_i     (uframe_i),
    .smask_i  (smask_i),
    .cmask_i  (cmask_i),
    .back_t_i (back_t_i),
    .active_i (cur_active_i),
    .cplt_i   (cur_cplt_i),
    .retired_i(retired_q && (uframe_i != '0)),
    .act_o    (act)
  );

  isosplit_update u_update (
    .d_i     (tgt_q ? bk_q : cur_q),
    .start_i (start_q),
    .code_i  (rsp_e'(rsp_code_i)),
    .d_o     (upd_d),
    .wb_o    (upd_wb),
    .retire_o(upd_retire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= S_IDLE;
      cur_q     <= '0;
      bk_q      <= '0;
      start_q   <= 1'b0;
      tgt_q     <= 1'b0;
      retired_q <= 1'b0;
      rt_q      <= 1'b0;
    end else begin
      unique case (st_q)
        S_IDLE: if (visit_valid_i) begin
          cur_q   <= '{active: cur_active_i, cplt: cur_cplt_i, err: 1'b0, cnt: cur_cnt_i};
          rt_q    <= 1'b0;
          tgt_q   <= 1'b0;
          start_q <= (act == ACT_START);
          if (uframe_i == '0) retired_q <= 1'b0;
          unique case (act)
            ACT_START, ACT_CPLT: st_q <= S_ISSUE;
            ACT_WRAP:            st_q <= S_FETCH;
            ACT_SKIP: begin
              cur_q.cplt <= 1'b0;
              st_q       <= S_WB_CUR;
            end
            default:             st_q <= S_FIN;
          endcase
        end
        S_FETCH: if (bk_vld_i) begin
          bk_q <= '{active: bk_active_i, cplt: bk_cplt_i, err: 1'b0, cnt: bk_cnt_i};
          if (bk_active_i && bk_cplt_i) begin
            tgt_q <= 1'b1;
            st_q  <= S_ISSUE;
          end else begin
            retired_q  <= 1'b1;
            cur_q.cplt <= 1'b0;
            st_q       <= S_WB_CUR;
          end
        end
        S_ISSUE: if (rsp_valid_i) begin
          if (tgt_q) begin
            bk_q <= upd_d;
            rt_q <= upd_retire;
            if (upd_retire) begin
              retired_q  <= 1'b1;
              cur_q.cplt <= 1'b0;
            end
            st_q <= upd_wb ? S_WB_BK : S_FIN;
          end else begin
            cur_q <= upd_d;
            st_q  <= upd_wb ? S_WB_CUR : S_FIN;
          end
        end
        S_WB_BK:  st_q <= rt_q ? S_WB_CUR : S_FIN;
        S_WB_CUR: st_q <= S_FIN;
        default:  st_q <= S_IDLE;
      endcase
    end
  end

  assign bk_req_o    = (st_q == S_FETCH);
  assign cmd_valid_o = (st_q == S_ISSUE);
  assign cmd_start_o = start_q;
  assign cmd_back_o  = tgt_q;
  assign wb_valid_o  = (st_q == S_WB_BK) || (st_q == S_WB_CUR);
  assign wb_back_o   = (st_q == S_WB_BK);
  assign wb_active_o = wb_back_o ? bk_q.active : cur_q.active;
  assign wb_cplt_o   = wb_back_o ? bk_q.cplt   : cur_q.cplt;
  assign wb_err_o    = wb_back_o ? bk_q.err    : cur_q.err;
  assign wb_cnt_o    = wb_back_o ? bk_q.cnt    : cur_q.cnt;
  assign done_o      = (st_q == S_FIN);

  a_r13_one_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cmd_valid_o, bk_req_o, wb_valid_o, done_o}));

  a_r13_cmd_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !rsp_valid_i |=> cmd_valid_o && $stable(cmd_back_o) && $stable(cmd_start_o));

  a_r2_start_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && rsp_valid_i && cmd_start_o && rsp_code_i != 2'd3
    |=> wb_valid_o && !wb_back_o && wb_cplt_o && wb_active_o);

  a_r6_mdata_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && rsp_valid_i && !cmd_start_o && rsp_code_i == 2'd1
    |=> wb_valid_o && wb_active_o && (wb_back_o == $past(cmd_back_o)));

  a_r7_err_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && rsp_valid_i && rsp_code_i == 2'd3
    |=> wb_valid_o && wb_err_o && !wb_active_o);

  a_r9_retire_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o && wb_back_o && !wb_active_o |=> wb_valid_o && !wb_back_o && !wb_cplt_o);

  a_r12_inactive_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == S_IDLE && visit_valid_i && !cur_active_i |=> done_o);
endmodule

// File: tb/tb_isosplit_seq.sv
module tb_isosplit_seq;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       visit_valid = 0, back_t = 1, cur_active = 0, cur_cplt = 0;
  logic [2:0] uframe = 0;
  logic [7:0] smask = 0, cmask = 0;
  logic [3:0] cur_cnt = 0, bk_cnt_in = 0;
  logic       bk_vld = 0, bk_active_in = 0, bk_cplt_in = 0;
  logic       rsp_valid = 0;
  logic [1:0] rsp_code = 0;
  logic       bk_req, cmd_valid, cmd_start, cmd_back;
  logic       wb_valid, wb_back, wb_active, wb_cplt, wb_err, done;
  logic [3:0] wb_cnt;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic ret_m = 0;

  always #4 clk = ~clk;

  isosplit_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .visit_valid_i(visit_valid), .uframe_i(uframe),
    .smask_i(smask), .cmask_i(cmask), .back_t_i(back_t), .cur_active_i(cur_active),
    .cur_cplt_i(cur_cplt), .cur_cnt_i(cur_cnt), .bk_req_o(bk_req), .bk_vld_i(bk_vld),
    .bk_active_i(bk_active_in), .bk_cplt_i(bk_cplt_in), .bk_cnt_i(bk_cnt_in),
    .cmd_valid_o(cmd_valid), .cmd_start_o(cmd_start), .cmd_back_o(cmd_back),
    .rsp_valid_i(rsp_valid), .rsp_code_i(rsp_code), .wb_valid_o(wb_valid),
    .wb_back_o(wb_back), .wb_active_o(wb_active), .wb_cplt_o(wb_cplt),
    .wb_err_o(wb_err), .wb_cnt_o(wb_cnt), .done_o(done)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // write-back record: {back, active, cplt, err, cnt}
  function automatic logic [7:0] pack(input bit b, input bit a, input bit c, input bit e, input logic [3:0] n);
    return {b, a, c, e, n};
  endfunction

  // complete-split outcome: returns wb enable, updates fields, sets retire
  function automatic bit cs_upd(input logic [1:0] code, inout bit a, inout bit c, inout bit e,
                                inout logic [3:0] n, output bit rt);
    rt = 0;
    case (code)
      2'd0: begin n = n + 1; a = 0; c = 0; rt = 1; return 1; end
      2'd1: begin n = n + 1; return 1; end
      2'd2: return 0;
      default: begin e = 1; a = 0; c = 0; rt = 1; return 1; end
    endcase
  endfunction

  task automatic visit(input logic [2:0] uf, input logic [7:0] sm, input logic [7:0] cm,
                       input bit bt, input bit act, input bit cp, input logic [3:0] cn,
                       input bit ba, input bit bc, input logic [3:0] bn, input logic [1:0] code);
    // expected
    int  lowest = 8;
    bit  e_fetch = 0, e_cmd = 0, e_start = 0, e_back = 0, win, rt;
    int  e_nwb = 0;
    logic [7:0] e_wb [2];
    string tag = "R3";
    bit a, c, e; logic [3:0] n;
    // observed
    bit  o_fetch = 0, o_cmd = 0, o_start = 0, o_back = 0, sent_b = 0, sent_r = 0;
    int  o_nwb = 0, wait_r = 0, guard = 0;
    logic [7:0] o_wb [2];
    e_wb[0] = 0; e_wb[1] = 0; o_wb[0] = 0; o_wb[1] = 0;

    for (int i = 7; i >= 0; i--) if (sm[i]) lowest = i;
    if (uf == 0) ret_m = 0;
    win = cp && cm[uf] && (int'(uf) < lowest) && !bt;
    if (!act) tag = "R12";
    else if (win && ret_m) begin
      tag = "R9"; e_nwb = 1; e_wb[0] = pack(0, 1, 0, 0, cn);
    end else if (win) begin
      e_fetch = 1;
      if (ba && bc) begin
        tag = "R8"; e_cmd = 1; e_back = 1;
        a = 1; c = 1; e = 0; n = bn;
        if (cs_upd(code, a, c, e, n, rt)) begin e_wb[0] = pack(1, a, c, e, n); e_nwb = 1; end
        if (rt) begin tag = "R9"; ret_m = 1; e_wb[1] = pack(0, 1, 0, 0, cn); e_nwb = 2; end
      end else begin
        tag = "R10"; ret_m = 1; e_nwb = 1; e_wb[0] = pack(0, 1, 0, 0, cn);
      end
    end else if (sm[uf] && (!cp || !bt)) begin
      tag = cp ? "R11" : "R2"; e_cmd = 1; e_start = 1; e_nwb = 1;
      e_wb[0] = (code == 3) ? pack(0, 0, 0, 1, cn) : pack(0, 1, 1, 0, cn);
    end else if (cp && cm[uf]) begin
      e_cmd = 1; a = 1; c = 1; e = 0; n = cn;
      tag = (code == 0) ? "R5" : (code == 1) ? "R6" : "R7";
      if (cs_upd(code, a, c, e, n, rt)) begin e_wb[0] = pack(0, a, c, e, n); e_nwb = 1; end
      if (code == 1 || code == 0) tag = (code == 0) ? "R5" : "R6";
      else if (!(code == 2 || code == 3)) tag = "R4";
    end

    // drive
    @(negedge clk);
    visit_valid = 1; uframe = uf; smask = sm; cmask = cm; back_t = bt;
    cur_active = act; cur_cplt = cp; cur_cnt = cn;
    bk_active_in = ba; bk_cplt_in = bc; bk_cnt_in = bn; rsp_code = code;
    @(negedge clk);
    visit_valid = 0;
    forever begin
      bk_vld = 0; rsp_valid = 0;
      if (done) break;
      if (bk_req && !sent_b) begin o_fetch = 1; bk_vld = 1; sent_b = 1; end
      if (cmd_valid) begin
        o_cmd = 1; o_start = cmd_start; o_back = cmd_back;
        if (!sent_r && wait_r >= 1) begin rsp_valid = 1; sent_r = 1; end
        wait_r++;
      end
      if (wb_valid) begin
        if (o_nwb < 2) o_wb[o_nwb] = pack(wb_back, wb_active, wb_cplt, wb_err, wb_cnt);
        o_nwb++;
      end
      guard++;
      if (guard > 40) begin check(0, {tag, " visit hung"}, guard, 40); break; end
      @(negedge clk);
    end
    bk_vld = 0; rsp_valid = 0;

    check(o_fetch == e_fetch, {tag, " fetch"}, o_fetch, e_fetch);
    check(o_cmd == e_cmd, {tag, " cmd"}, o_cmd, e_cmd);
    if (e_cmd && o_cmd)
      check({o_start, o_back} == {e_start, e_back}, {tag, " cmd kind/target"},
            {o_start, o_back}, {e_start, e_back});
    check(o_nwb == e_nwb, {tag, " wb count"}, o_nwb, e_nwb);
    for (int k = 0; k < 2; k++)
      if (k < e_nwb && k < o_nwb)
        check(o_wb[k] == e_wb[k], {tag, " wb fields"}, o_wb[k], e_wb[k]);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1 reset state
    check({cmd_valid, bk_req, wb_valid, done} == 4'b0, "R1 reset outputs",
          {cmd_valid, bk_req, wb_valid, done}, 0);
    rst_n = 1;
    @(negedge clk);
    check({cmd_valid, bk_req, wb_valid, done} == 4'b0, "R1 after release",
          {cmd_valid, bk_req, wb_valid, done}, 0);

    // frame X: start at uf4, completes at uf6/7
    visit(3'd0, 8'h10, 8'hC3, 1, 1, 0, 4'd0, 0, 0, 0, 2'd0); // R3 cmask ignored
    visit(3'd1, 8'h10, 8'hC3, 1, 1, 0, 4'd0, 0, 0, 0, 2'd0); // R3
    visit(3'd4, 8'h10, 8'hC3, 1, 1, 0, 4'd0, 0, 0, 0, 2'd1); // R2
    visit(3'd6, 8'h10, 8'hC3, 1, 1, 1, 4'd0, 0, 0, 0, 2'd1); // R4/R6
    visit(3'd7, 8'h10, 8'hC3, 1, 1, 1, 4'd1, 0, 0, 0, 2'd2); // R7 not yet
    // frame X+1: wrap through back-link
    visit(3'd0, 8'h10, 8'hC3, 0, 1, 1, 4'd0, 1, 1, 4'd1, 2'd1); // R8 more data
    visit(3'd1, 8'h10, 8'hC3, 0, 1, 1, 4'd0, 1, 1, 4'd2, 2'd0); // R9 retire
    visit(3'd1, 8'h10, 8'hC3, 0, 1, 1, 4'd0, 1, 1, 4'd2, 2'd1); // R9 skip after retire
    visit(3'd4, 8'h10, 8'hC3, 0, 1, 0, 4'd0, 0, 0, 0, 2'd1);    // R2
    visit(3'd6, 8'h10, 8'hC3, 0, 1, 1, 4'd0, 0, 0, 0, 2'd0);    // R4/R5 (not wrap slot)
    // frame X+2: uf0 clears retired memory
    visit(3'd0, 8'h10, 8'hC3, 0, 1, 1, 4'd5, 1, 1, 4'd9, 2'd3); // R8/R7 error on back
    visit(3'd0, 8'h10, 8'hC3, 0, 1, 1, 4'd5, 0, 1, 4'd9, 2'd1); // R10 inactive back
    visit(3'd4, 8'h10, 8'hC3, 0, 1, 1, 4'd5, 0, 0, 0, 2'd1);    // R11
    visit(3'd4, 8'h10, 8'hC3, 1, 1, 0, 4'd5, 0, 0, 0, 2'd3);    // R7 start error
    visit(3'd4, 8'h10, 8'hC3, 1, 0, 0, 4'd5, 0, 0, 0, 2'd0);    // R12 inactive
    visit(3'd7, 8'h10, 8'hC3, 1, 1, 1, 4'hF, 0, 0, 0, 2'd0);    // R5 count wrap

    for (int t = 0; t < 400; t++) begin
      logic [7:0] sm = 8'($urandom), cm = 8'($urandom);
      visit(3'($urandom), sm, cm, 1'($urandom), ($urandom % 8) != 0, 1'($urandom),
            4'($urandom), 1'($urandom), 1'($urandom), 4'($urandom), 2'($urandom));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule